// File: doc/BRIEF.md
# Gated Tone-Burst Channel Sequencer

This block turns a slow, asynchronous on/off gate into a tone burst laid into a circular sample buffer, one independent controller per channel. Each controller asks an external sample generator for new samples by naming a buffer slot, and it holds the read pointer of a small playback engine. That engine steps through the buffer once per external sample tick. While the gate is high the buffer is kept topped up and playback wraps around the buffer without end.

When the gate drops, the controller does not recompute the samples that are already queued. It walks back over them and asks the generator to rescale each one to the next down-ramp step, so the sine phase carries on unbroken. If the queue is longer than the down ramp, the tail past the ramp is dropped by pulling the fill pointer back. Any remaining down-ramp samples are then requested. Playback is switched from endless wrapping to a single pass that stops on the last queued entry. When the engine reports that stop, the channel rearms for the next burst.

Top module: `tone_burst_seq`

## Requirements
- R1: While reset is held and right after it, every channel reports state code 0 (start), cfg_load high, run low, read pointer 0 and no sample or rescale request. State codes are: 0 start, 1 pre-fill, 2 launch, 3 run, 4 rework, 5 drain, 6 finish.
- R2: In start a channel pulses cfg_load for one cycle, clears its fill pointer, read pointer and ramp step, and stops playback (run low from the next cycle). It then enters pre-fill.
- R3: In pre-fill a sample request is raised whenever occupancy ((fill - read) mod DEPTH) is below DEPTH - GUARD, with slot equal to the fill pointer, which then advances by one. The gate passes through two synchronizing flops, and a synchronized high level moves the channel to launch.
- R4: Launch lasts one cycle and makes playback run in wrap mode (run and wrap high) from the next cycle, then enters run.
- R5: While playback runs, each tick advances the read pointer by one modulo DEPTH. With playback stopped, ticks have no effect.
- R6: In run, samples are requested while occupancy is below DEPTH - GUARD and the synchronized gate is high. A synchronized low gate moves the channel to rework with no request in that cycle.
- R7: In rework the channel issues one rescale request per cycle. Slots start at read pointer + 2, captured on entry, and ascend. The ramp step starts at 0 and increases by one with each request. It stops after min(occupancy - 2, off-ramp length) requests, where the occupancy (taken as 0 if not above 2) and the off-ramp length are both captured on entry. It then enters drain.
- R8: If rework stops because the ramp is used up while queued entries remain, the fill pointer is set to the slot just after the last rescaled one.
- R9: In drain, samples are requested at the fill pointer while occupancy is below DEPTH - GUARD and the ramp step is below the captured off-ramp length. The step keeps counting from where rework left it.
- R10: When the ramp step reaches the off-ramp length in drain, playback switches to single pass (wrap low) with terminal index fill - 1, and the channel enters finish.
- R11: In single pass, the tick that plays the terminal index stops playback. The channel in finish returns to start one cycle later.
- R12: Channels share no state: each runs its own gate, tick and off-ramp length through complete bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | NUM_CH | Asynchronous burst gate per channel |
| tick_i | input | NUM_CH | One-cycle sample tick per channel |
| off_len_i | input | NUM_CH*LW | Off-ramp length per channel, in samples |
| state_o | output | NUM_CH*3 | Channel state code |
| cfg_load_o | output | NUM_CH | Load burst parameters into the sample generator |
| gen_req_o | output | NUM_CH | Request a new sample at slot_o |
| resc_req_o | output | NUM_CH | Request rescale of the sample at slot_o |
| slot_o | output | NUM_CH*AW | Buffer slot for the current request |
| step_o | output | NUM_CH*LW | Down-ramp step index for the current request |
| rd_ptr_o | output | NUM_CH*AW | Playback read pointer |
| run_o | output | NUM_CH | Playback running |
| wrap_o | output | NUM_CH | Playback in continuous wrap mode |

## Verification
A wrong state shows up in the same cycle as a changed state code and a wrong request strobe. A wrong fill or rework pointer shows up in slot_o on the next request. A wrong capture of occupancy or ramp length shows up as a rework run that is too long or too short, one cycle after the expected exit. Playback faults show in rd_ptr_o on the tick after the fault, or as a burst that never returns to start. So every field of every channel is compared against the model on every cycle.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [2:0] {
    ST_START  = 3'd0,
    ST_PREF   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_RUN    = 3'd3,
    ST_REWORK = 3'd4,
    ST_DRAIN  = 3'd5,
    ST_FINISH = 3'd6
  } chan_st_e;
endpackage

// File: rtl/tbs_gate_sync.sv
module tbs_gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic gate_o
);
  logic meta_q, stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      meta_q   <= gate_i;
      stable_q <= meta_q;
    end
  end

  assign gate_o = stable_q;
endmodule

// File: rtl/tbs_playback.sv
module tbs_playback #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          single_i,
  input  logic [AW-1:0] term_i,
  input  logic          tick_i,
  output logic [AW-1:0] rd_o,
  output logic          run_o,
  output logic          wrap_o,
  output logic          done_o
);
  logic [AW-1:0] rd_q, rd_d, term_q, term_d;
  logic          run_q, run_d, single_q, single_d, done_q, done_d;

  always_comb begin
    rd_d     = rd_q;
    run_d    = run_q;
    single_d = single_q;
    term_d   = term_q;
    done_d   = 1'b0;
    if (clr_i) begin
      rd_d     = '0;
      run_d    = 1'b0;
      single_d = 1'b0;
    end else begin
      if (start_i) run_d = 1'b1;
      if (single_i) begin
        single_d = 1'b1;
        term_d   = term_i;
      end
      if (tick_i && run_q) begin
        rd_d = rd_q + AW'(1);
        if (single_q && (rd_q == term_q)) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      run_q    <= 1'b0;
      single_q <= 1'b0;
      term_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      rd_q     <= rd_d;
      run_q    <= run_d;
      single_q <= single_d;
      term_q   <= term_d;
      done_q   <= done_d;
    end
  end

  assign rd_o   = rd_q;
  assign run_o  = run_q;
  assign wrap_o = run_q & ~single_q;
  assign done_o = done_q;

  // R5: a running tick moves the read pointer by exactly one
  a_r5_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !clr_i) |=> (rd_q == $past(rd_q) + AW'(1)));
  // R5: no tick, no movement
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(rd_q));
  // R11: termination leaves playback stopped
  a_r11_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);
endmodule

// File: rtl/tbs_chan_ctrl.sv
module tbs_chan_ctrl
  import tbs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GUARD = 2,
  parameter int LW    = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CAP  = DEPTH - GUARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_s_i,
  input  logic [LW-1:0] off_len_i,
  input  logic [AW-1:0] rd_i,
  input  logic          run_i,
  input  logic          wrap_i,
  input  logic          done_i,
  output logic [2:0]    state_o,
  output logic          cfg_load_o,
  output logic          gen_req_o,
  output logic          resc_req_o,
  output logic [AW-1:0] slot_o,
  output logic [LW-1:0] step_o,
  output logic          pb_clr_o,
  output logic          pb_start_o,
  output logic          pb_single_o,
  output logic [AW-1:0] pb_term_o
);
  chan_st_e      st_q, st_d;
  logic [AW-1:0] fill_q, fill_d, mptr_q, mptr_d;
  logic [AW-1:0] mcnt_q, mcnt_d, mrem_q, mrem_d;
  logic [LW-1:0] k_q, k_d, olen_q, olen_d;
  logic [AW-1:0] occ;
  logic          room, ramp_left, rows_left;

  assign occ       = fill_q - rd_i;
  assign room      = ({1'b0, occ} < (AW+1)'(CAP));
  assign ramp_left = (k_q < olen_q);
  assign rows_left = (mcnt_q < mrem_q);

  always_comb begin
    st_d        = st_q;
    fill_d      = fill_q;
    mptr_d      = mptr_q;
    mcnt_d      = mcnt_q;
    mrem_d      = mrem_q;
    k_d         = k_q;
    olen_d      = olen_q;
    cfg_load_o  = 1'b0;
    gen_req_o   = 1'b0;
    resc_req_o  = 1'b0;
    pb_clr_o    = 1'b0;
    pb_start_o  = 1'b0;
    pb_single_o = 1'b0;
    unique case (st_q)
      ST_START: begin
        cfg_load_o = 1'b1;
        pb_clr_o   = 1'b1;
        fill_d     = '0;
        k_d        = '0;
        st_d       = ST_PREF;
      end
      ST_PREF: begin
        gen_req_o = room;
        if (room) fill_d = fill_q + AW'(1);
        if (gate_s_i) st_d = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        pb_start_o = 1'b1;
        st_d       = ST_RUN;
      end
      ST_RUN: begin
        gen_req_o = room & gate_s_i;
        if (room && gate_s_i) fill_d = fill_q + AW'(1);
        if (!gate_s_i) begin
          st_d   = ST_REWORK;
          mptr_d = rd_i + AW'(2);
          mcnt_d = '0;
          mrem_d = (occ > AW'(2)) ? (occ - AW'(2)) : '0;
          olen_d = off_len_i;
          k_d    = '0;
        end
      end
      ST_REWORK: begin
        if (rows_left && ramp_left) begin
          resc_req_o = 1'b1;
          mptr_d     = mptr_q + AW'(1);
          mcnt_d     = mcnt_q + AW'(1);
          k_d        = k_q + LW'(1);
        end else begin
          st_d = ST_DRAIN;
          if (rows_left) fill_d = mptr_q;
        end
      end
      ST_DRAIN: begin
        gen_req_o = room & ramp_left;
        if (room && ramp_left) begin
          fill_d = fill_q + AW'(1);
          k_d    = k_q + LW'(1);
        end
        if (!ramp_left) begin
          pb_single_o = 1'b1;
          st_d        = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (done_i) st_d = ST_START;
      end
      default: st_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_START;
      fill_q <= '0;
      mptr_q <= '0;
      mcnt_q <= '0;
      mrem_q <= '0;
      k_q    <= '0;
      olen_q <= '0;
    end else begin
      st_q   <= st_d;
      fill_q <= fill_d;
      mptr_q <= mptr_d;
      mcnt_q <= mcnt_d;
      mrem_q <= mrem_d;
      k_q    <= k_d;
      olen_q <= olen_d;
    end
  end

  assign state_o   = st_q;
  assign slot_o    = (st_q == ST_REWORK) ? mptr_q : fill_q;
  assign step_o    = k_q;
  assign pb_term_o = fill_q - AW'(1);

  // R6: queued data never closer than GUARD to the read pointer
  a_r6_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, occ} <= (AW+1)'(CAP)));
  // R2: start leaves playback stopped
  a_r2_start_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |=> !run_i);
  // R4: launch turns on wrapping playback
  a_r4_launch_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAUNCH) |=> (run_i && wrap_i));
  // R10: finish always runs a single pass
  a_r10_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINISH) |-> !wrap_i);
  // R7: never a new sample and a rescale together
  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_req_o && resc_req_o));
  // R3: synchronized gate high in pre-fill launches
  a_r3_go: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PREF && gate_s_i) |=> (st_q == ST_LAUNCH));
  // R6: synchronized gate low in run starts rework
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !gate_s_i) |=> (st_q == ST_REWORK));
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq #(
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 16,
  parameter int GUARD  = 2,
  parameter int LW     = 6,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    gate_i,
  input  logic [NUM_CH-1:0]    tick_i,
  input  logic [NUM_CH*LW-1:0] off_len_i,
  output logic [NUM_CH*3-1:0]  state_o,
  output logic [NUM_CH-1:0]    cfg_load_o,
  output logic [NUM_CH-1:0]    gen_req_o,
  output logic [NUM_CH-1:0]    resc_req_o,
  output logic [NUM_CH*AW-1:0] slot_o,
  output logic [NUM_CH*LW-1:0] step_o,
  output logic [NUM_CH*AW-1:0] rd_ptr_o,
  output logic [NUM_CH-1:0]    run_o,
  output logic [NUM_CH-1:0]    wrap_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          gate_s, pb_clr, pb_start, pb_single, pb_done;
    logic [AW-1:0] pb_term, rd;
    logic          run, wrap;

    tbs_gate_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .gate_i(gate_i[c]),
      .gate_o(gate_s)
    );

    tbs_chan_ctrl #(.DEPTH(DEPTH), .GUARD(GUARD), .LW(LW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_s_i   (gate_s),
      .off_len_i  (off_len_i[c*LW +: LW]),
      .rd_i       (rd),
      .run_i      (run),
      .wrap_i     (wrap),
      .done_i     (pb_done),
      .state_o    (state_o[c*3 +: 3]),
      .cfg_load_o (cfg_load_o[c]),
      .gen_req_o  (gen_req_o[c]),
      .resc_req_o (resc_req_o[c]),
      .slot_o     (slot_o[c*AW +: AW]),
      .step_o     (step_o[c*LW +: LW]),
      .pb_clr_o   (pb_clr),
      .pb_start_o (pb_start),
      .pb_single_o(pb_single),
      .pb_term_o  (pb_term)
    );

    tbs_playback #(.AW(AW)) u_play (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (pb_clr),
      .start_i (pb_start),
      .single_i(pb_single),
      .term_i  (pb_term),
      .tick_i  (tick_i[c]),
      .rd_o    (rd),
      .run_o   (run),
      .wrap_o  (wrap),
      .done_o  (pb_done)
    );

    assign rd_ptr_o[c*AW +: AW] = rd;
    assign run_o[c]             = run;
    assign wrap_o[c]            = wrap;
  end
endmodule

// File: tb/sim_tone_burst_seq.sv
module sim_tone_burst_seq;
  localparam int NCH = 3, D = 16, G = 2, LW = 6, AW = 4, CAP = D - G;
  localparam int BURSTS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] gate = '0, tick = '0;
  logic [NCH*LW-1:0] off_len = '0;
  logic [NCH*3-1:0] state_o;
  logic [NCH-1:0] cfg_load_o, gen_req_o, resc_req_o, run_o, wrap_o;
  logic [NCH*AW-1:0] slot_o, rd_ptr_o;
  logic [NCH*LW-1:0] step_o;

  always #2 clk = ~clk;

  tone_burst_seq #(.NUM_CH(NCH), .DEPTH(D), .GUARD(G), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .tick_i(tick), .off_len_i(off_len),
    .state_o(state_o), .cfg_load_o(cfg_load_o), .gen_req_o(gen_req_o),
    .resc_req_o(resc_req_o), .slot_o(slot_o), .step_o(step_o),
    .rd_ptr_o(rd_ptr_o), .run_o(run_o), .wrap_o(wrap_o));

  int n_chk = 0, n_err = 0;
  int m_st[NCH], m_fill[NCH], m_rd[NCH], m_run[NCH], m_sgl[NCH], m_term[NCH];
  int m_done[NCH], m_s1[NCH], m_s2[NCH], m_mptr[NCH], m_mcnt[NCH], m_mrem[NCH];
  int m_k[NCH], m_olen[NCH];
  int bursts_seen[NCH];
  int prev_st[NCH];
  int tperiod[NCH] = '{3, 5, 7};
  int tcnt[NCH];
  bit started = 0;

  task automatic chk(string tag, string what, int c, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s ch%0d %s actual=%0d expected=%0d", tag, c, what, act, exp);
    end
  endtask

  function automatic string tag_of(int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7,R8";
      5: return "R9,R10";
      default: return "R11";
    endcase
  endfunction

  // reference model, updated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0; m_fill[c] = 0; m_rd[c] = 0; m_run[c] = 0; m_sgl[c] = 0;
        m_term[c] = 0; m_done[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_mptr[c] = 0;
        m_mcnt[c] = 0; m_mrem[c] = 0; m_k[c] = 0; m_olen[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int st, fill, rd, occ, gs, clr, start, sgl, mcnt, mrem, mptr, k;
        bit room, rl;
        st = m_st[c]; fill = m_fill[c]; rd = m_rd[c]; gs = m_s2[c];
        mcnt = m_mcnt[c]; mrem = m_mrem[c]; mptr = m_mptr[c]; k = m_k[c];
        occ = (fill - rd + D) % D;
        room = occ < CAP;
        rl = k < m_olen[c];
        clr = 0; start = 0; sgl = 0;
        m_s2[c] = m_s1[c];
        m_s1[c] = gate[c];
        case (st)
          0: begin clr = 1; m_fill[c] = 0; m_k[c] = 0; m_st[c] = 1; end
          1: begin
            if (room) m_fill[c] = (fill + 1) % D;
            if (gs) m_st[c] = 2;
          end
          2: begin start = 1; m_st[c] = 3; end
          3: begin
            if (room && gs) m_fill[c] = (fill + 1) % D;
            if (!gs) begin
              m_st[c] = 4; m_mptr[c] = (rd + 2) % D; m_mcnt[c] = 0;
              m_mrem[c] = (occ > 2) ? occ - 2 : 0;
              m_olen[c] = int'(off_len[c*LW +: LW]); m_k[c] = 0;
            end
          end
          4: begin
            if (mcnt < mrem && rl) begin
              m_mptr[c] = (mptr + 1) % D; m_mcnt[c] = mcnt + 1; m_k[c] = k + 1;
            end else begin
              m_st[c] = 5;
              if (mcnt < mrem) m_fill[c] = mptr;
            end
          end
          5: begin
            if (room && rl) begin m_fill[c] = (fill + 1) % D; m_k[c] = k + 1; end
            if (!rl) begin sgl = 1; m_st[c] = 6; end
          end
          default: if (m_done[c] != 0) m_st[c] = 0;
        endcase
        if (clr) begin
          m_rd[c] = 0; m_run[c] = 0; m_sgl[c] = 0; m_done[c] = 0;
        end else begin
          int old_sgl, old_term, old_run;
          old_sgl = m_sgl[c]; old_term = m_term[c]; old_run = m_run[c];
          m_done[c] = 0;
          if (start) m_run[c] = 1;
          if (sgl) begin m_sgl[c] = 1; m_term[c] = (fill - 1 + D) % D; end
          if (tick[c] && old_run != 0) begin
            m_rd[c] = (rd + 1) % D;
            if (old_sgl != 0 && rd == old_term) begin m_run[c] = 0; m_done[c] = 1; end
          end
        end
      end
    end
  end

  // compare every field of every channel away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int c = 0; c < NCH; c++) begin
        int occ, st, e_gen, e_resc, e_slot;
        string t;
        st = m_st[c];
        t = tag_of(st);
        occ = (m_fill[c] - m_rd[c] + D) % D;
        e_gen = 0; e_resc = 0;
        if (st == 1) e_gen = occ < CAP;
        if (st == 3) e_gen = (occ < CAP) && (m_s2[c] != 0);
        if (st == 5) e_gen = (occ < CAP) && (m_k[c] < m_olen[c]);
        if (st == 4) e_resc = (m_mcnt[c] < m_mrem[c]) && (m_k[c] < m_olen[c]);
        e_slot = (st == 4) ? m_mptr[c] : m_fill[c];
        chk(t, "state", c, int'(state_o[c*3 +: 3]), st);
        chk(t, "cfg_load", c, int'(cfg_load_o[c]), st == 0);
        chk(t, "gen_req", c, int'(gen_req_o[c]), e_gen);
        chk(t, "resc_req", c, int'(resc_req_o[c]), e_resc);
        chk(t, "slot", c, int'(slot_o[c*AW +: AW]), e_slot);
        chk(t, "step", c, int'(step_o[c*LW +: LW]), m_k[c]);
        chk("R5", "rd_ptr", c, int'(rd_ptr_o[c*AW +: AW]), m_rd[c]);
        chk(t, "run", c, int'(run_o[c]), m_run[c]);
        chk(t, "wrap", c, int'(wrap_o[c]), (m_run[c] != 0) && (m_sgl[c] == 0));
        if (prev_st[c] == 6 && int'(state_o[c*3 +: 3]) == 0) bursts_seen[c]++;
        prev_st[c] = int'(state_o[c*3 +: 3]);
      end
    end
  end

  // per-channel sample ticks at different rates
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      tick[c] <= (tcnt[c] == 0) && rst_n;
      tcnt[c] = (tcnt[c] + 1) % tperiod[c];
    end
  end

  task automatic run_chan(int c);
    int olens[BURSTS];
    case (c)
      0: olens = '{3, 0, 9};
      1: olens = '{20, 5, 0};
      default: olens = '{0, 12, 40};
    endcase
    for (int b = 0; b < BURSTS; b++) begin
      repeat (20 + 7 * c) @(negedge clk);
      off_len[c*LW +: LW] = LW'(olens[b]);
      gate[c] = 1'b1;
      repeat (60 + 25 * b + 11 * c) @(negedge clk);
      gate[c] = 1'b0;
      @(negedge clk);
      while (int'(state_o[c*3 +: 3]) != 1) @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin tcnt[c] = 0; bursts_seen[c] = 0; prev_st[c] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state of every channel
    for (int c = 0; c < NCH; c++) begin
      chk("R1", "reset state", c, int'(state_o[c*3 +: 3]), 0);
      chk("R1", "reset cfg_load", c, int'(cfg_load_o[c]), 1);
      chk("R1", "reset run", c, int'(run_o[c]), 0);
      chk("R1", "reset rd_ptr", c, int'(rd_ptr_o[c*AW +: AW]), 0);
      chk("R1", "reset gen_req", c, int'(gen_req_o[c]), 0);
      chk("R1", "reset resc_req", c, int'(resc_req_o[c]), 0);
    end
    rst_n = 1'b1;
    started = 1;
    fork
      run_chan(0);
      run_chan(1);
      run_chan(2);
    join
    repeat (10) @(negedge clk);
    // R12: every channel completed its own bursts independently
    for (int c = 0; c < NCH; c++) chk("R12", "bursts completed", c, bursts_seen[c], BURSTS);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule